// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Carry, Half-Carry and Zero Flags

This block is the arithmetic and logic unit of a small 8-bit accumulator controller, together with the three-bit status register it keeps up to date. Each cycle it takes two operands and an operation code and produces a result at once, without a clock. The operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR, increment, decrement and rotate left or right through carry. When `exec` is high, the next clock edge writes the flags that the operation affects into the register. A flag is written only if its bit in the update-enable mask is also set.

The flag register also sits in the data address space. The CPU can read it and overwrite it through a simple register port at a fixed address, which is a parameter that defaults to 86h. Subtraction uses the inverted-borrow convention: a set carry means that no borrow occurred. The half-carry flag follows the same convention for the low nibble. Instruction decode and writeback of the result live outside the block.

Top module: `acc_alu8`

## Requirements
- R1: After reset all three flags are 0, and a read of the flag address returns 00h.
- R2: Opcodes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, INC=7, DEC=8, RLC=9 and RRC=10. ADD gives A+B and ADC gives A+B+C, both modulo 256. On both, C becomes the carry out of bit 7.
- R3: SUB gives A+~B+1 and SBC gives A+~B+C, both modulo 256. On both, C becomes 1 when no borrow occurs and 0 when a borrow occurs.
- R4: On ADD, ADC, SUB and SBC, DC becomes the carry out of bit 3 of the same sum. For subtraction this means DC=1 when the low nibble does not borrow.
- R5: Every opcode except RLC and RRC sets Z to 1 when its result is 00h and to 0 otherwise.
- R6: AND, OR, XOR, INC and DEC change only Z, and C and DC hold their values. INC of FFh gives 00h and DEC of 00h gives FFh.
- R7: RLC gives {A[6:0],C} and loads C from A[7]. RRC gives {C,A[7:1]} and loads C from A[0]. Both leave DC and Z unchanged.
- R8: The flags change only on a clock edge where `exec` is high or the register is written. The bits of `upd_en` are C=bit 2, DC=bit 1 and Z=bit 0. A flag whose enable bit is 0 holds its value.
- R9: A write to the flag address loads C from bit 2, DC from bit 1 and Z from bit 0 of the write data. A read of that address returns the flags in the same bit positions, with bits 7..3 equal to 0. A write to any other address changes no flag, and a read of any other address returns 00h.
- R10: When a register write to the flag address and `exec` occur on the same edge, the register write sets all three flags.
- R11: The opcodes 11 to 15 give a result of 00h and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Commit the flags of the current operation on the next edge |
| op | input | 4 | Operation code |
| opa | input | 8 | First operand (accumulator side) |
| opb | input | 8 | Second operand |
| upd_en | input | 3 | Per-flag update enable: [2]=C, [1]=DC, [0]=Z |
| reg_addr | input | 8 | Address of the register port |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| result | output | 8 | Result of the operation (combinational) |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_dc | output | 1 | Low-nibble carry / no-borrow flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench aims at the edges of the carry convention. It subtracts equal values, where a design that treats C as a plain borrow would clear C instead of setting it. It also subtracts a larger value from a smaller one and checks that both C and DC fall. Sums that wrap to exactly 00h check that Z and C are set together. Nibble-only carries such as 08h+08h would expose a DC taken from the wrong bit. The rotates, increment and decrement run with the flags preset to 1, so a unit that touched a flag outside its class, or rotated in a constant instead of C, would show the wrong flag. Cleared enable bits, register writes to a wrong address and register writes that race `exec` each catch a different mistake in the order in which the flag register is loaded.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;
   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_INC = 4'd7,
      OP_DEC = 4'd8,
      OP_RLC = 4'd9,
      OP_RRC = 4'd10
   } alu_op_e;

   localparam int FLAG_BITS = 3;

   // bit 2 = carry, bit 1 = half carry, bit 0 = zero
   typedef struct packed {
      logic c;
      logic dc;
      logic z;
   } flags_t;
endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
   parameter int W      = 8,
   parameter int NIB    = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         nib_cout
);
   generate
      if (NIB < 1 || NIB >= W) begin : g_bad_nib
         $error("acc_adder: NIB must lie in 1..W-1");
      end
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1]  = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         assign cout     = cy[W];
         assign nib_cout = cy[NIB];
      end else begin : g_behav
         logic [W:0]   full;
         logic [NIB:0] low;
         assign full     = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         assign low      = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
         assign sum      = full[W-1:0];
         assign cout     = full[W];
         assign nib_cout = low[NIB];
      end
   endgenerate
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter int NIB    = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         c_in,
   output logic [W-1:0] res,
   output flags_t       nxt,
   output flags_t       aff
);
   logic [W-1:0] add_b;
   logic         add_cin;
   logic [W-1:0] sum;
   logic         cout;
   logic         nib_cout;

   acc_adder #(.W(W), .NIB(NIB), .RIPPLE(RIPPLE)) u_add (
      .a        (a),
      .b        (add_b),
      .cin      (add_cin),
      .sum      (sum),
      .cout     (cout),
      .nib_cout (nib_cout)
   );

   // operand selection for the shared adder
   always_comb begin
      add_b   = b;
      add_cin = 1'b0;
      case (op)
         OP_ADC:  add_cin = c_in;
         OP_SUB:  begin add_b = ~b; add_cin = 1'b1; end
         OP_SBC:  begin add_b = ~b; add_cin = c_in; end
         OP_INC:  begin add_b = '0; add_cin = 1'b1; end
         OP_DEC:  begin add_b = '1; add_cin = 1'b0; end
         default: ;
      endcase
   end

   // result and flag candidates
   always_comb begin
      res    = '0;
      aff    = '0;
      nxt.c  = cout;
      nxt.dc = nib_cout;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
            res = sum;
            aff = '{c: 1'b1, dc: 1'b1, z: 1'b1};
         end
         OP_INC, OP_DEC: begin
            res   = sum;
            aff.z = 1'b1;
         end
         OP_AND: begin res = a & b; aff.z = 1'b1; end
         OP_OR:  begin res = a | b; aff.z = 1'b1; end
         OP_XOR: begin res = a ^ b; aff.z = 1'b1; end
         OP_RLC: begin
            res   = {a[W-2:0], c_in};
            nxt.c = a[W-1];
            aff.c = 1'b1;
         end
         OP_RRC: begin
            res   = {c_in, a[W-1:1]};
            nxt.c = a[0];
            aff.c = 1'b1;
         end
         default: ;
      endcase
      nxt.z = (res == '0);
   end
endmodule

// File: rtl/acc_flag_file.sv
module acc_flag_file
   import acc_alu8_pkg::*;
#(
   parameter int          W     = 8,
   parameter int          AW    = 8,
   parameter logic [AW-1:0] ADDR = 8'h86
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exec,
   input  flags_t        aff,
   input  flags_t        nxt,
   input  logic [2:0]    upd_en,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_wr,
   input  logic [W-1:0]  reg_wdata,
   output logic [W-1:0]  reg_rdata,
   output flags_t        flags
);
   localparam int PAD = W - FLAG_BITS;

   generate
      if (W <= FLAG_BITS) begin : g_bad_w
         $error("acc_flag_file: data width must exceed the flag count");
      end
   endgenerate

   logic   hit;
   logic   wr_hit;
   flags_t wr_val;

   assign hit    = (reg_addr == ADDR);
   assign wr_hit = reg_wr && hit;
   assign wr_val = flags_t'(reg_wdata[FLAG_BITS-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (wr_hit) begin
         flags <= wr_val;
      end else if (exec) begin
         if (aff.c  && upd_en[2]) flags.c  <= nxt.c;
         if (aff.dc && upd_en[1]) flags.dc <= nxt.dc;
         if (aff.z  && upd_en[0]) flags.z  <= nxt.z;
      end
   end

   assign reg_rdata = hit ? {{PAD{1'b0}}, flags} : '0;

   // R9: a register write lands in the flags on the next edge
   p_write_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (flags == $past(reg_wdata[FLAG_BITS-1:0])));

   // R9: reads away from the flag address return zero
   p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (reg_rdata == '0));

   // R8: no exec and no write means no change
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec && !wr_hit) |=> $stable(flags));

   // R8: a masked carry holds
   p_masked_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && !wr_hit && !upd_en[2]) |=> $stable(flags.c));

   // R7: an op that does not touch Z leaves it alone
   p_unaffected_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && !wr_hit && !aff.z) |=> $stable(flags.z));

   // R6: an op that does not touch DC leaves it alone
   p_unaffected_dc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && !wr_hit && !aff.dc) |=> $stable(flags.dc));
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
   import acc_alu8_pkg::*;
#(
   parameter int            DATA_W     = 8,
   parameter int            NIB_W      = 4,
   parameter int            ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h86,
   parameter bit            USE_RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [2:0]        upd_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] result,
   output logic              flag_c,
   output logic              flag_dc,
   output logic              flag_z
);
   flags_t cur;
   flags_t nxt;
   flags_t aff;

   acc_alu_core #(.W(DATA_W), .NIB(NIB_W), .RIPPLE(USE_RIPPLE)) u_core (
      .op   (op),
      .a    (opa),
      .b    (opb),
      .c_in (cur.c),
      .res  (result),
      .nxt  (nxt),
      .aff  (aff)
   );

   acc_flag_file #(.W(DATA_W), .AW(ADDR_W), .ADDR(FLAG_ADDR)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .exec      (exec),
      .aff       (aff),
      .nxt       (nxt),
      .upd_en    (upd_en),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .flags     (cur)
   );

   assign flag_c  = cur.c;
   assign flag_dc = cur.dc;
   assign flag_z  = cur.z;

   // R11: unassigned opcodes yield zero
   p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op > 4'd10) |-> (result == '0));
endmodule

// File: tb/sim_acc_alu8.sv
module sim_acc_alu8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       exec = 1'b0;
   logic [3:0] op = '0;
   logic [7:0] opa = '0, opb = '0;
   logic [2:0] upd_en = 3'b111;
   logic [7:0] reg_addr = 8'h86;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata, result;
   logic       flag_c, flag_dc, flag_z;

   int checks = 0;
   int errors = 0;
   logic m_c = 1'b0, m_dc = 1'b0, m_z = 1'b0;

   typedef struct packed {
      logic [7:0] res;
      logic [7:0] rd;
      logic [2:0] fl;
      logic [7:0] req;
   } item_t;
   item_t q[$];
   bit driving_done = 1'b0;

   always #10 clk = ~clk;

   acc_alu8 u0 (
      .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .opa(opa), .opb(opb),
      .upd_en(upd_en), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .result(result), .flag_c(flag_c), .flag_dc(flag_dc),
      .flag_z(flag_z)
   );

   task automatic check(input int req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and pushes the model's prediction
   task automatic drive(input logic ex, input int o, input int a, input int b,
                        input logic [2:0] en, input int addr, input logic wr,
                        input int wd, input int req);
      int r; logic nc, ndc, nz, af_c, af_dc, af_z;
      int s, lo;
      item_t it;
      @(posedge clk); #3;
      exec = ex; op = 4'(o); opa = 8'(a); opb = 8'(b); upd_en = en;
      reg_addr = 8'(addr); reg_wr = wr; reg_wdata = 8'(wd);
      r = 0; nc = m_c; ndc = 1'b0; af_c = 0; af_dc = 0; af_z = 0;
      case (o)
         0, 1: begin
            s  = a + b + ((o == 1) ? int'(m_c) : 0);
            lo = (a % 16) + (b % 16) + ((o == 1) ? int'(m_c) : 0);
            r = s % 256; nc = (s > 255); ndc = (lo > 15); af_c = 1; af_dc = 1; af_z = 1;
         end
         2, 3: begin
            s  = a + (255 - b) + ((o == 2) ? 1 : int'(m_c));
            lo = (a % 16) + (15 - (b % 16)) + ((o == 2) ? 1 : int'(m_c));
            r = s % 256; nc = (s > 255); ndc = (lo > 15); af_c = 1; af_dc = 1; af_z = 1;
         end
         4: begin r = a & b; af_z = 1; end
         5: begin r = a | b; af_z = 1; end
         6: begin r = a ^ b; af_z = 1; end
         7: begin r = (a + 1) % 256; af_z = 1; end
         8: begin r = (a + 255) % 256; af_z = 1; end
         9: begin r = ((a * 2) % 256) + int'(m_c); nc = (a >= 128); af_c = 1; end
         10: begin r = (a / 2) + (m_c ? 128 : 0); nc = (a % 2 == 1); af_c = 1; end
         default: r = 0;
      endcase
      nz = (r == 0);
      it.res = 8'(r);
      it.rd  = (addr == 'h86) ? {5'b0, m_c, m_dc, m_z} : 8'h00;
      it.req = 8'(req);
      if (wr && addr == 'h86) begin
         m_c = wd[2]; m_dc = wd[1]; m_z = wd[0];
      end else if (ex) begin
         if (af_c && en[2]) m_c = nc;
         if (af_dc && en[1]) m_dc = ndc;
         if (af_z && en[0]) m_z = nz;
      end
      it.fl = {m_c, m_dc, m_z};
      q.push_back(it);
   endtask

   // monitor: result and read data before the edge, flags after it
   initial begin
      forever begin
         item_t it;
         wait (q.size() > 0);
         @(negedge clk);
         it = q.pop_front();
         check(int'(it.req), "result", int'(result), int'(it.res));
         check(int'(it.req), "rdata", int'(reg_rdata), int'(it.rd));
         @(posedge clk); #1;
         check(int'(it.req), "flags", int'({flag_c, flag_dc, flag_z}), int'(it.fl));
      end
   end

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(1, "reset flags", int'({flag_c, flag_dc, flag_z}), 0);
      check(1, "reset rdata", int'(reg_rdata), 0);
      rst_n = 1'b1;
      // R2 add / adc
      drive(1, 0, 'h35, 'h51, 3'b111, 'h86, 0, 0, 2);
      drive(1, 0, 'hF0, 'h10, 3'b111, 'h86, 0, 0, 2);   // wraps: C=1 Z=1 (R5)
      drive(1, 1, 'h7F, 'h00, 3'b111, 'h86, 0, 0, 2);   // C=1 enters: 80h
      drive(1, 0, 'h08, 'h08, 3'b111, 'h86, 0, 0, 4);   // R4 nibble carry only
      drive(1, 1, 'hFF, 'hFF, 3'b111, 'h86, 0, 0, 2);
      // R3 sub / sbc
      drive(1, 2, 'h05, 'h05, 3'b111, 'h86, 0, 0, 3);   // no borrow: C=1 DC=1 Z=1
      drive(1, 2, 'h03, 'h05, 3'b111, 'h86, 0, 0, 3);   // borrow: C=0 DC=0
      drive(1, 3, 'h10, 'h01, 3'b111, 'h86, 0, 0, 3);   // C=0 -> extra borrow
      drive(1, 3, 'h20, 'h01, 3'b111, 'h86, 0, 0, 4);   // low nibble borrows only
      // R6 logic and inc/dec touch only Z
      drive(0, 0, 0, 0, 3'b111, 'h86, 1, 'h07, 9);
      drive(1, 4, 'hF0, 'h0F, 3'b111, 'h86, 0, 0, 6);
      drive(1, 5, 'hA0, 'h05, 3'b111, 'h86, 0, 0, 6);
      drive(1, 6, 'h5A, 'h5A, 3'b111, 'h86, 0, 0, 5);
      drive(1, 7, 'hFF, 0, 3'b111, 'h86, 0, 0, 6);
      drive(1, 8, 'h00, 0, 3'b111, 'h86, 0, 0, 6);
      // R7 rotates
      drive(0, 0, 0, 0, 3'b111, 'h86, 1, 'h07, 9);
      drive(1, 9, 'h4B, 0, 3'b111, 'h86, 0, 0, 7);
      drive(1, 9, 'h80, 0, 3'b111, 'h86, 0, 0, 7);
      drive(1, 10, 'h01, 0, 3'b111, 'h86, 0, 0, 7);
      drive(1, 10, 'h00, 0, 3'b111, 'h86, 0, 0, 7);
      // R8 per-flag enables and idle hold
      drive(0, 0, 0, 0, 3'b111, 'h86, 1, 'h00, 9);
      drive(1, 0, 'hFF, 'h01, 3'b010, 'h86, 0, 0, 8);
      drive(1, 0, 'hFF, 'h01, 3'b101, 'h86, 0, 0, 8);
      drive(0, 2, 'h01, 'h02, 3'b111, 'h86, 0, 0, 8);
      // R9 register port
      drive(0, 0, 0, 0, 3'b111, 'h86, 1, 'hFA, 9);
      drive(0, 0, 0, 0, 3'b111, 'h85, 1, 'h00, 9);
      drive(0, 0, 0, 0, 3'b111, 'h85, 0, 0, 9);
      drive(0, 0, 0, 0, 3'b111, 'h86, 0, 0, 9);
      // R10 write wins over exec
      drive(1, 0, 'hFF, 'h01, 3'b111, 'h86, 1, 'h02, 10);
      drive(0, 0, 0, 0, 3'b111, 'h86, 0, 0, 10);
      // R11 unassigned opcodes
      drive(1, 11, 'h12, 'h34, 3'b111, 'h86, 0, 0, 11);
      drive(1, 15, 'hFF, 'hFF, 3'b111, 'h86, 0, 0, 11);
      drive(0, 0, 0, 0, 3'b111, 'h86, 0, 0, 11);
      driving_done = 1'b1;
      wait (q.size() == 0);
      @(posedge clk); #5;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule